// File: doc/BRIEF.md
# Wavefront Macroblock Address Sequencer

This block produces, at run time, the order in which macroblocks are read from an input buffer. The order lets a linear chain of filtering units work on a frame as a diagonal wavefront. The chain holds `cfg_cols × cfg_rows` units. Unit 0 is the top of the first column, and the unit after the bottom of a column is the top of the next column. The frame measures `cfg_width × cfg_height` macroblocks. Each unit filters every macroblock of one frame row, from left to right. Each macroblock goes to the same unit as its left neighbour, one processing cycle later.

When the frame has more macroblock rows than the chain has units, the frame is split into horizontal stripes that are as tall as the unit count, and the stripes are taken from top to bottom. Within a stripe, each unit starts `SKEW` cycles after the unit before it, which covers the dependency on the upper-right neighbour. On every processing cycle the block emits one slot per unit, in unit-index order. A slot carries either the macroblock number, which is also the buffer address `row × width + column`, or a null marker. Every slot is held under a ready/valid handshake. The first slot and the last slot of a frame are flagged, and a one-clock done pulse follows the last slot.

The control is a three-state machine:
- ST_IDLE waits for an acceptable start. The transition *accept* goes from ST_IDLE to ST_EMIT.
- ST_EMIT presents slots. The transition *slot* advances within ST_EMIT on each handshake. The transition *frame_end* goes to ST_DONE when the final slot is taken.
- ST_DONE lasts one clock. The transition *rearm* then returns to ST_IDLE.

Top module: `wavefront_mb_sequencer`

## Requirements
- R1: After reset the block is in ST_IDLE, with `slot_valid` and `done` both low, and stays there until an acceptable start.
- R2: A `start` seen in ST_IDLE is accepted only when all four configuration values are nonzero. If any value is zero, the start is ignored and `slot_valid` stays low. On acceptance the configuration is latched, so later changes on the configuration ports have no effect on the running frame.
- R3: With U = cfg_cols × cfg_rows units, each processing cycle emits exactly U slots. Their unit indices on `slot_unit` run 0, 1, …, U−1.
- R4: A non-null slot of unit i, in the stripe whose first frame row is r0, carries `slot_mb = (r0 + i) × width + column`.
- R5: On cycle t of a stripe, unit i is given column t − SKEW·i when that value lies in 0..width−1. Otherwise its slot has `slot_null = 1` and `slot_mb = 0`. SKEW defaults to 2.
- R6: A stripe with R active rows lasts width + SKEW·(R−1) cycles. Stripes follow one another top to bottom with no gap in `slot_valid`.
- R7: In a final stripe with fewer than U rows, units with index ≥ R receive only null slots.
- R8: While `slot_valid` is high and `slot_ready` is low, every slot output is held stable.
- R9: `slot_sof` is high only on the first slot of a frame (unit 0, cycle 0, first stripe). `slot_eof` is high only on the last slot of the frame (unit U−1, last cycle, last stripe).
- R10: `done` is high for exactly one clock, in the cycle after the handshake of the `slot_eof` slot. During that clock `slot_valid` is low. A new start is accepted afterwards.
- R11: A `start` asserted while a frame is being emitted is ignored, and the sequence continues unchanged.
- R12: Every macroblock address from 0 to width × height − 1 is emitted exactly once per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cols | input | ARR_W | Array columns M |
| cfg_rows | input | ARR_W | Units per column N |
| cfg_width | input | DIM_W | Frame width in macroblocks |
| cfg_height | input | DIM_W | Frame height in macroblocks |
| start | input | 1 | Begin a frame (accepted in ST_IDLE only) |
| slot_valid | output | 1 | A slot is presented |
| slot_ready | input | 1 | Consumer takes the slot |
| slot_unit | output | 2·ARR_W | Unit index of the slot |
| slot_null | output | 1 | Slot is a null filler |
| slot_mb | output | 2·DIM_W | Macroblock number / buffer address |
| slot_sof | output | 1 | First slot of the frame |
| slot_eof | output | 1 | Last slot of the frame |
| done | output | 1 | One-clock frame-complete pulse |

## Verification
The bench runs these corner cases:

- **Partial final stripe.** A sequencer that miscounted the rows of a partial final stripe would either give real addresses to idle units or cut the stripe short, so some macroblocks would never appear.
- **More units than frame rows, and a one-column frame.** These are where an off-by-one in the skewed column window shows up: one column is emitted twice, or the diagonal is shifted by one unit.
- **Backpressure.** Irregular ready patterns would expose a design that advanced its counters without a handshake, which skips slots.
- **Stray start and configuration changes.** A `start` pulse and new configuration values arrive mid-frame. A design that restarted, or that read the live ports instead of latched values, would produce a different sequence.

// File: rtl/wf_seq_pkg.sv
package wf_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EMIT = 2'd1,
        ST_DONE = 2'd2
    } wf_state_e;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wf_cfg_regs.sv
module wf_cfg_regs #(
    parameter int ARR_W  = 3,
    parameter int DIM_W  = 7,
    parameter int UNIT_W = 2 * ARR_W,
    parameter int STEP_W = UNIT_W + DIM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ARR_W-1:0]  cols_in,
    input  logic [ARR_W-1:0]  rows_in,
    input  logic [DIM_W-1:0]  width_in,
    input  logic [DIM_W-1:0]  height_in,
    output logic              cfg_ok,
    output logic [UNIT_W-1:0] units_q,
    output logic [DIM_W-1:0]  width_q,
    output logic [DIM_W-1:0]  height_q,
    output logic [STEP_W-1:0] step_q
);

    logic [UNIT_W-1:0] units_nx;

    always_comb begin
        cfg_ok   = (cols_in != '0) && (rows_in != '0) &&
                   (width_in != '0) && (height_in != '0);
        units_nx = UNIT_W'(cols_in) * UNIT_W'(rows_in);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            units_q  <= '0;
            width_q  <= '0;
            height_q <= '0;
            step_q   <= '0;
        end else if (load) begin
            units_q  <= units_nx;
            width_q  <= width_in;
            height_q <= height_in;
            step_q   <= STEP_W'(units_nx) * STEP_W'(width_in);
        end
    end

endmodule

// File: rtl/wf_slot_calc.sv
module wf_slot_calc #(
    parameter int DIM_W  = 7,
    parameter int UNIT_W = 6,
    parameter int ROW_W  = 8,
    parameter int CYC_W  = 11,
    parameter int ADDR_W = 14
) (
    input  logic [CYC_W-1:0]  cyc,
    input  logic [CYC_W-1:0]  lag,
    input  logic [UNIT_W-1:0] unit,
    input  logic [ROW_W-1:0]  rows_act,
    input  logic [DIM_W-1:0]  width,
    input  logic [ADDR_W-1:0] row_addr,
    output logic              is_null,
    output logic [ADDR_W-1:0] mb
);

    localparam int CMP_W = (UNIT_W > ROW_W) ? UNIT_W : ROW_W;

    logic signed [CYC_W:0] col;
    logic                  col_ok;
    logic                  unit_ok;

    always_comb begin
        col     = $signed({1'b0, cyc}) - $signed({1'b0, lag});
        col_ok  = (col >= 0) && (col < $signed({1'b0, CYC_W'(width)}));
        unit_ok = CMP_W'(unit) < CMP_W'(rows_act);
        is_null = !(col_ok && unit_ok);
        mb      = is_null ? '0 : row_addr + ADDR_W'(col[CYC_W-1:0]);
    end

endmodule

// File: rtl/wavefront_mb_sequencer.sv
module wavefront_mb_sequencer
    import wf_seq_pkg::*;
#(
    parameter int ARR_W  = 3,
    parameter int DIM_W  = 7,
    parameter int SKEW   = 2,
    parameter int UNIT_W = 2 * ARR_W,
    parameter int ADDR_W = 2 * DIM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ARR_W-1:0]  cfg_cols,
    input  logic [ARR_W-1:0]  cfg_rows,
    input  logic [DIM_W-1:0]  cfg_width,
    input  logic [DIM_W-1:0]  cfg_height,
    input  logic              start,
    output logic              slot_valid,
    input  logic              slot_ready,
    output logic [UNIT_W-1:0] slot_unit,
    output logic              slot_null,
    output logic [ADDR_W-1:0] slot_mb,
    output logic              slot_sof,
    output logic              slot_eof,
    output logic              done
);

    localparam int ROW_W  = max_int(DIM_W, UNIT_W) + 1;
    localparam int SKEW_W = $clog2(SKEW + 1);
    localparam int CYC_W  = ROW_W + SKEW_W + 1;
    localparam int STEP_W = UNIT_W + DIM_W;

    wf_state_e state, state_nx;

    logic              cfg_ok;
    logic [UNIT_W-1:0] units_q;
    logic [DIM_W-1:0]  width_q;
    logic [DIM_W-1:0]  height_q;
    logic [STEP_W-1:0] step_q;

    logic [ROW_W-1:0]  row0;
    logic [ADDR_W-1:0] stripe_base;
    logic [ADDR_W-1:0] row_addr;
    logic [CYC_W-1:0]  cyc;
    logic [CYC_W-1:0]  lag;
    logic [UNIT_W-1:0] unit;

    logic [ROW_W-1:0]  rows_left;
    logic [ROW_W-1:0]  units_ext;
    logic [ROW_W-1:0]  rows_act;
    logic [CYC_W-1:0]  last_cyc_val;
    logic              last_unit;
    logic              last_cyc;
    logic              last_stripe;
    logic              accept;
    logic              hs;
    logic              calc_null;
    logic [ADDR_W-1:0] calc_mb;

    wf_cfg_regs #(
        .ARR_W  (ARR_W),
        .DIM_W  (DIM_W),
        .UNIT_W (UNIT_W),
        .STEP_W (STEP_W)
    ) i_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .cols_in   (cfg_cols),
        .rows_in   (cfg_rows),
        .width_in  (cfg_width),
        .height_in (cfg_height),
        .cfg_ok    (cfg_ok),
        .units_q   (units_q),
        .width_q   (width_q),
        .height_q  (height_q),
        .step_q    (step_q)
    );

    wf_slot_calc #(
        .DIM_W  (DIM_W),
        .UNIT_W (UNIT_W),
        .ROW_W  (ROW_W),
        .CYC_W  (CYC_W),
        .ADDR_W (ADDR_W)
    ) i_calc (
        .cyc      (cyc),
        .lag      (lag),
        .unit     (unit),
        .rows_act (rows_act),
        .width    (width_q),
        .row_addr (row_addr),
        .is_null  (calc_null),
        .mb       (calc_mb)
    );

    // Stripe geometry and end-of-sequence decodes
    always_comb begin
        rows_left    = ROW_W'(height_q) - row0;
        units_ext    = ROW_W'(units_q);
        rows_act     = (rows_left < units_ext) ? rows_left : units_ext;
        last_cyc_val = CYC_W'(width_q) - CYC_W'(1)
                     + CYC_W'(SKEW) * (CYC_W'(rows_act) - CYC_W'(1));
        last_unit    = (unit == units_q - UNIT_W'(1));
        last_cyc     = (cyc == last_cyc_val);
        last_stripe  = (row0 + units_ext) >= ROW_W'(height_q);
        accept       = (state == ST_IDLE) && start && cfg_ok;
        hs           = (state == ST_EMIT) && slot_ready;
    end

    // Next-state decode
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (accept) state_nx = ST_EMIT;
            ST_EMIT: if (hs && last_unit && last_cyc && last_stripe)
                         state_nx = ST_DONE;
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Wavefront position counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row0        <= '0;
            stripe_base <= '0;
            row_addr    <= '0;
            cyc         <= '0;
            lag         <= '0;
            unit        <= '0;
        end else if (accept) begin
            row0        <= '0;
            stripe_base <= '0;
            row_addr    <= '0;
            cyc         <= '0;
            lag         <= '0;
            unit        <= '0;
        end else if (hs) begin
            if (last_unit) begin
                unit <= '0;
                lag  <= '0;
                if (last_cyc) begin
                    cyc         <= '0;
                    row0        <= row0 + units_ext;
                    stripe_base <= stripe_base + ADDR_W'(step_q);
                    row_addr    <= stripe_base + ADDR_W'(step_q);
                end else begin
                    cyc      <= cyc + CYC_W'(1);
                    row_addr <= stripe_base;
                end
            end else begin
                unit     <= unit + UNIT_W'(1);
                lag      <= lag + CYC_W'(SKEW);
                row_addr <= row_addr + ADDR_W'(width_q);
            end
        end
    end

    // Outputs
    always_comb begin
        slot_valid = 1'b0;
        done       = 1'b0;
        slot_sof   = 1'b0;
        slot_eof   = 1'b0;
        slot_unit  = unit;
        slot_null  = calc_null;
        slot_mb    = calc_mb;
        unique case (state)
            ST_IDLE: ;
            ST_EMIT: begin
                slot_valid = 1'b1;
                slot_sof   = (cyc == '0) && (unit == '0) && (row0 == '0);
                slot_eof   = last_unit && last_cyc && last_stripe;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/wf_seq_checker.sv
module wf_seq_checker #(
    parameter int UNIT_W = 6,
    parameter int ADDR_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              slot_valid,
    input logic              slot_ready,
    input logic [UNIT_W-1:0] slot_unit,
    input logic              slot_null,
    input logic [ADDR_W-1:0] slot_mb,
    input logic              slot_sof,
    input logic              slot_eof,
    input logic              done
);

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && !slot_ready) |=> slot_valid && $stable(slot_mb) &&
        $stable(slot_unit) && $stable(slot_null) && $stable(slot_sof) &&
        $stable(slot_eof));

    assert_null_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && slot_null) |-> (slot_mb == '0));

    assert_sof_unit0_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && slot_sof) |-> (slot_unit == '0));

    assert_unit_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && slot_ready && !slot_eof) |=> slot_valid &&
        ((slot_unit == UNIT_W'($past(slot_unit) + 1'b1)) || (slot_unit == '0)));

    assert_done_after_eof_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && slot_ready && slot_eof) |=> (done && !slot_valid));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_start_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && start && !(slot_ready && slot_eof)) |=> slot_valid);

    assert_valid_done_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(slot_valid && done));

endmodule

bind wavefront_mb_sequencer wf_seq_checker #(
    .UNIT_W (UNIT_W),
    .ADDR_W (ADDR_W)
) i_wf_seq_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .slot_valid (slot_valid),
    .slot_ready (slot_ready),
    .slot_unit  (slot_unit),
    .slot_null  (slot_null),
    .slot_mb    (slot_mb),
    .slot_sof   (slot_sof),
    .slot_eof   (slot_eof),
    .done       (done)
);

// File: tb/test_wavefront_mb_sequencer.sv
`timescale 1ns/1ps
module test_wavefront_mb_sequencer;

    localparam int ARR_W  = 3;
    localparam int DIM_W  = 7;
    localparam int SKEW   = 2;
    localparam int UNIT_W = 2 * ARR_W;
    localparam int ADDR_W = 2 * DIM_W;

    // cols, rows, width, height, ready pattern
    localparam int N_CFG = 7;
    localparam int CFG_TAB [N_CFG][5] = '{
        '{1, 1, 4, 3, 0},
        '{1, 2, 5, 5, 1},
        '{2, 2, 3, 4, 0},
        '{2, 3, 6, 4, 1},
        '{3, 1, 1, 7, 0},
        '{2, 1, 7, 2, 2},
        '{1, 3, 2, 8, 2}
    };

    logic              clk;
    logic              rst_n;
    logic [ARR_W-1:0]  cfg_cols;
    logic [ARR_W-1:0]  cfg_rows;
    logic [DIM_W-1:0]  cfg_width;
    logic [DIM_W-1:0]  cfg_height;
    logic              start;
    logic              slot_valid;
    logic              slot_ready;
    logic [UNIT_W-1:0] slot_unit;
    logic              slot_null;
    logic [ADDR_W-1:0] slot_mb;
    logic              slot_sof;
    logic              slot_eof;
    logic              done;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  finished = 0;
    int  rdy_k = 0;
    int  ready_mode = 0;
    int  slot_idx = 0;
    int  inject_at = -1;
    bit  broken = 0;
    int  seen [1024];

    wavefront_mb_sequencer #(
        .ARR_W (ARR_W),
        .DIM_W (DIM_W),
        .SKEW  (SKEW)
    ) i_wavefront_mb_sequencer (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_cols   (cfg_cols),
        .cfg_rows   (cfg_rows),
        .cfg_width  (cfg_width),
        .cfg_height (cfg_height),
        .start      (start),
        .slot_valid (slot_valid),
        .slot_ready (slot_ready),
        .slot_unit  (slot_unit),
        .slot_null  (slot_null),
        .slot_mb    (slot_mb),
        .slot_sof   (slot_sof),
        .slot_eof   (slot_eof),
        .done       (done)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Called at a negedge; returns at the negedge after the handshake.
    task automatic expect_slot(input int eu, input bit en, input int ea,
                               input bit es, input bit ee, input string nreq);
        bit got = 0;
        while (!got) begin
            start = (slot_idx == inject_at);
            rdy_k++;
            case (ready_mode)
                0:       slot_ready = 1'b1;
                1:       slot_ready = (rdy_k % 3 != 1);
                default: slot_ready = rdy_k[0];
            endcase
            if (!slot_valid) begin
                check(0, "R6", "slot_valid gap", 0, 1);
                broken = 1;
                got = 1;
            end else if (slot_ready) begin
                check(slot_unit == UNIT_W'(eu), "R3", "slot_unit", slot_unit, eu);
                check(slot_null == en, nreq, "slot_null", slot_null, en);
                check(slot_mb == ADDR_W'(ea), en ? "R5" : "R4", "slot_mb", slot_mb, ea);
                check(slot_sof == es && slot_eof == ee, "R9", "sof/eof",
                      {slot_sof, slot_eof}, {es, ee});
                if (!slot_null && slot_mb < 1024) seen[slot_mb]++;
                got = 1;
                @(negedge clk);
            end else begin
                logic [ADDR_W-1:0] h_mb;
                logic [UNIT_W-1:0] h_unit;
                h_mb   = slot_mb;
                h_unit = slot_unit;
                @(negedge clk);
                check(slot_valid && slot_mb == h_mb && slot_unit == h_unit,
                      "R8", "held slot", slot_mb, h_mb);
            end
        end
        slot_idx++;
    endtask

    task automatic run_frame(input int m, input int n, input int w, input int h,
                             input int mode);
        int u;
        u = m * n;
        ready_mode = mode;
        for (int a = 0; a < 1024; a++) seen[a] = 0;
        cfg_cols   = ARR_W'(m);
        cfg_rows   = ARR_W'(n);
        cfg_width  = DIM_W'(w);
        cfg_height = DIM_W'(h);
        slot_ready = 1'b0;
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R2: live configuration changes must not affect the latched frame
        cfg_cols   = 3'd7;
        cfg_rows   = 3'd7;
        cfg_width  = 7'd1;
        cfg_height = 7'd1;
        slot_idx   = 0;
        inject_at  = (mode != 0) ? 3 : -1;  // R11: stray start mid-frame
        broken     = 0;
        for (int r0 = 0; r0 < h && !broken; r0 += u) begin
            int rs;
            int len;
            rs  = (h - r0 < u) ? (h - r0) : u;
            len = w + SKEW * (rs - 1);
            for (int t = 0; t < len && !broken; t++) begin
                for (int i = 0; i < u && !broken; i++) begin
                    int  col;
                    bit  act;
                    col = t - SKEW * i;
                    act = (i < rs) && (col >= 0) && (col < w);
                    expect_slot(i, !act, act ? (r0 + i) * w + col : 0,
                                (r0 == 0 && t == 0 && i == 0),
                                (r0 + u >= h && t == len - 1 && i == u - 1),
                                (i >= rs) ? "R7" : "R5");
                end
            end
        end
        start = 1'b0;
        slot_ready = 1'b0;
        check(done == 1'b1 && slot_valid == 1'b0, "R10", "done after eof", done, 1);
        @(negedge clk);
        check(done == 1'b0, "R10", "done one clock", done, 0);
        begin
            int bad;
            bad = 0;
            for (int a = 0; a < w * h; a++) if (seen[a] != 1) bad++;
            check(bad == 0, "R12", "addresses not seen once", bad, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n      = 1'b0;
        start      = 1'b0;
        slot_ready = 1'b0;
        cfg_cols   = '0;
        cfg_rows   = '0;
        cfg_width  = '0;
        cfg_height = '0;
        repeat (3) @(negedge clk);
        check(slot_valid == 1'b0 && done == 1'b0, "R1", "outputs in reset",
              {slot_valid, done}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(slot_valid == 1'b0 && done == 1'b0, "R1", "idle after reset",
              {slot_valid, done}, 0);

        // R2: start with a zero dimension is ignored
        cfg_cols = 3'd2; cfg_rows = 3'd2; cfg_width = 7'd0; cfg_height = 7'd4;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        check(slot_valid == 1'b0, "R2", "zero width start ignored", slot_valid, 0);
        cfg_cols = 3'd0; cfg_width = 7'd3;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        check(slot_valid == 1'b0, "R2", "zero cols start ignored", slot_valid, 0);

        // Table of configurations, one frame each (R3-R12)
        for (int k = 0; k < N_CFG; k++) begin
            run_frame(CFG_TAB[k][0], CFG_TAB[k][1], CFG_TAB[k][2],
                      CFG_TAB[k][3], CFG_TAB[k][4]);
            @(negedge clk);
        end

        // Back-to-back: start right after done is accepted again (R10)
        run_frame(1, 1, 1, 1, 0);
        run_frame(3, 2, 3, 2, 1);

        finished = 1;
        summary();
        $finish;
    end

endmodule